// File: doc/BRIEF.md
# Commit-Protected Pin Configuration Register Block

This block holds the per-pin configuration of a small group of pins, some of which normally serve a debug port. Three configuration registers are kept, each one bit per pin: function select (1 picks the alternate/debug function, 0 leaves the pin as plain GPIO), pull-up enable and digital enable. Their contents leave the block as three control vectors that drive a pin multiplexer.

Some pins are marked protected by a parameter. Out of reset, every protected pin comes up with function select, pull-up and digital enable all set, so the debug port is usable at once. Software can change a protected bit only after two steps. First it writes a 32-bit key to the key register to open the gate. Then it sets the matching bit in the commit mask. Unprotected bits take every write at once. Any value other than the key closes the gate again. The commit mask can itself only be changed while the gate is open.

A write port takes valid, address and data. A read port takes a request and an address, and returns the data one cycle later with a valid flag.

Top module: `pincfg_regs`

## Requirements
- R1: After reset the function-select register (word address 0) holds 1 in every protected bit (default bits [3:0]) and 0 elsewhere, and `alt_sel_o` shows the same value.
- R2: After reset the pull-up register (word address 1) holds 1 in every protected bit and 0 elsewhere, and `pull_up_o` shows the same value.
- R3: After reset the digital-enable register (word address 2) holds 1 in every protected bit and 0 elsewhere, and `dig_en_o` shows the same value.
- R4: A permitted write of 0 to a protected function-select bit clears that bit of `alt_sel_o` on the next cycle, which returns the pin to GPIO use.
- R5: The gate is closed after reset. A write to word address 3 opens it when the data equals `UNLOCK_KEY` (default 32'hA5C3_0F1E) and closes it for any other data. A read of address 3 returns 0 while the gate is open and 1 while it is closed.
- R6: While the gate is closed, a write to any configuration register leaves every protected bit unchanged.
- R7: While the gate is open, a protected bit of a configuration register takes the written value only if its commit-mask bit is 1. Otherwise it keeps its value.
- R8: The commit mask (word address 4) resets to 0 and changes only on writes made while the gate is open. Its unprotected bits always read 0.
- R9: Unprotected bits of the configuration registers take the written value on every write, whatever the state of the gate and the mask.
- R10: A read request returns `rd_valid_o` high with the register value (zero-extended) on the next cycle. Any address other than 0 to 4 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | DATA_W | Read data |
| alt_sel_o | output | NPINS | Per-pin alternate-function select |
| pull_up_o | output | NPINS | Per-pin pull-up enable |
| dig_en_o | output | NPINS | Per-pin digital enable |

## Verification
The bench writes 0 to protected bits while the gate is closed. A design that ignores the gate would drop the debug function at this point. Writes are also sent while the gate is open but the mask is clear, which catches a design that checks only the gate. The commit mask is written while the gate is closed, and a key write is followed by a non-key write. A gate that sticks open, or a mask that can always be written, shows up in the readback. Free bits are written in the same words as blocked ones, so that a mask applied to the whole register fails.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;
  localparam int unsigned NUM_CFG     = 3;
  localparam int unsigned ADDR_FN     = 0;
  localparam int unsigned ADDR_PU     = 1;
  localparam int unsigned ADDR_DE     = 2;
  localparam int unsigned ADDR_KEY    = 3;
  localparam int unsigned ADDR_COMMIT = 4;
  localparam int unsigned VEC_W       = 32;

  // Bits that may be updated by a write: every free bit, plus committed
  // protected bits while the gate is open.
  function automatic logic [VEC_W-1:0] upd_mask(input logic [VEC_W-1:0] prot,
                                                input logic [VEC_W-1:0] commit,
                                                input logic             open);
    logic [VEC_W-1:0] guarded;
    guarded = open ? (prot & commit) : '0;
    return (~prot) | guarded;
  endfunction

  function automatic logic [VEC_W-1:0] merge(input logic [VEC_W-1:0] old_v,
                                             input logic [VEC_W-1:0] new_v,
                                             input logic [VEC_W-1:0] en);
    return (new_v & en) | (old_v & ~en);
  endfunction
endpackage

// File: rtl/pincfg_gate.sv
module pincfg_gate #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);
  logic key_match;
  assign key_match = (wdata_i == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    open_o <= 1'b0;
    else if (wr_i) open_o <= key_match;
  end

  a_r5_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == KEY) |=> open_o);
  a_r5_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i != KEY) |=> !open_o);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(open_o));
endmodule

// File: rtl/pincfg_commit.sv
module pincfg_commit #(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PROT = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic             open_i,
  output logic [NPINS-1:0] commit_o
);
  logic accept;
  assign accept = wr_i && open_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      commit_o <= '0;
    else if (accept) commit_o <= wdata_i & PROT;
  end

  a_r8_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(commit_o));
  a_r8_free_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o & ~PROT) == '0);
endmodule

// File: rtl/pincfg_field.sv
module pincfg_field #(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PROT    = 8'h0F,
  parameter logic [NPINS-1:0] RST_VAL = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic             open_i,
  input  logic [NPINS-1:0] commit_i,
  output logic [NPINS-1:0] q_o
);
  import pincfg_pkg::*;

  logic [NPINS-1:0] en_bits;
  logic [NPINS-1:0] next_q;

  assign en_bits = NPINS'(upd_mask(VEC_W'(PROT), VEC_W'(commit_i), open_i));
  assign next_q  = NPINS'(merge(VEC_W'(q_o), VEC_W'(wdata_i), VEC_W'(en_bits)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (wr_i) q_o <= next_q;
  end

  a_r6_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(q_o & PROT));
  a_r7_uncommitted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((q_o & PROT & ~$past(commit_i)) == ($past(q_o) & PROT & ~$past(commit_i))));
  a_r9_free_take: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((q_o & ~PROT) == ($past(wdata_i) & ~PROT)));
endmodule

// File: rtl/pincfg_regs.sv
module pincfg_regs #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [NPINS-1:0]  PROT_MASK  = 8'h0F,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NPINS-1:0]  alt_sel_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  dig_en_o
);
  import pincfg_pkg::*;

  localparam logic [NPINS-1:0] RST_CFG = PROT_MASK;

  logic [NPINS-1:0] cfg_q [NUM_CFG];
  logic [NPINS-1:0] commit_q;
  logic             gate_open;
  logic             wr_key, wr_commit;
  logic [DATA_W-1:0] rd_mux;
  logic             rd_mapped;

  assign wr_key    = wr_valid_i && (wr_addr_i == ADDR_W'(ADDR_KEY));
  assign wr_commit = wr_valid_i && (wr_addr_i == ADDR_W'(ADDR_COMMIT));

  pincfg_gate #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_key), .wdata_i(wr_data_i),
    .open_o(gate_open));

  pincfg_commit #(.NPINS(NPINS), .PROT(PROT_MASK)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_commit), .wdata_i(wr_data_i[NPINS-1:0]),
    .open_i(gate_open), .commit_o(commit_q));

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic hit;
    assign hit = wr_valid_i && (wr_addr_i == ADDR_W'(g));
    pincfg_field #(.NPINS(NPINS), .PROT(PROT_MASK), .RST_VAL(RST_CFG)) u_field (
      .clk(clk), .rst_n(rst_n), .wr_i(hit), .wdata_i(wr_data_i[NPINS-1:0]),
      .open_i(gate_open), .commit_i(commit_q), .q_o(cfg_q[g]));
  end

  assign alt_sel_o = cfg_q[ADDR_FN];
  assign pull_up_o = cfg_q[ADDR_PU];
  assign dig_en_o  = cfg_q[ADDR_DE];

  always_comb begin
    rd_mux    = '0;
    rd_mapped = 1'b1;
    if      (rd_addr_i == ADDR_W'(ADDR_FN))     rd_mux = DATA_W'(cfg_q[ADDR_FN]);
    else if (rd_addr_i == ADDR_W'(ADDR_PU))     rd_mux = DATA_W'(cfg_q[ADDR_PU]);
    else if (rd_addr_i == ADDR_W'(ADDR_DE))     rd_mux = DATA_W'(cfg_q[ADDR_DE]);
    else if (rd_addr_i == ADDR_W'(ADDR_KEY))    rd_mux = DATA_W'(!gate_open);
    else if (rd_addr_i == ADDR_W'(ADDR_COMMIT)) rd_mux = DATA_W'(commit_q);
    else                                        rd_mapped = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_mapped) |=> (rd_data_o == '0));
  a_r4_alt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_addr_i == ADDR_W'(ADDR_FN) && gate_open) |=>
      ((alt_sel_o & $past(commit_q)) == ($past(wr_data_i[NPINS-1:0]) & $past(commit_q))));
endmodule

// File: tb/tb_pincfg_regs.sv
`timescale 1ns/1ps
module tb_pincfg_regs;
  localparam int NPINS = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [7:0]  PROT = 8'h0F;
  localparam logic [31:0] KEY  = 32'hA5C3_0F1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [NPINS-1:0] alt_sel, pull_up, dig_en;

  always #2 clk = ~clk;

  pincfg_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .alt_sel_o(alt_sel),
    .pull_up_o(pull_up), .dig_en_o(dig_en));

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference state kept from the requirements
  logic [7:0] m_fn = PROT, m_pu = PROT, m_de = PROT, m_cm = 8'h00;
  logic       m_open = 1'b0;

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] apply_cfg(input logic [7:0] old_v, input logic [7:0] d);
    logic [7:0] r = old_v;
    for (int i = 0; i < 8; i++)
      if (!PROT[i] || (m_open && m_cm[i])) r[i] = d[i];
    return r;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    case (a)
      0: m_fn = apply_cfg(m_fn, d[7:0]);
      1: m_pu = apply_cfg(m_pu, d[7:0]);
      2: m_de = apply_cfg(m_de, d[7:0]);
      3: m_open = (d == KEY);
      4: if (m_open) m_cm = d[7:0] & PROT;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_rd(input int a);
    case (a)
      0: return {24'h0, m_fn};
      1: return {24'h0, m_pu};
      2: return {24'h0, m_de};
      3: return {31'h0, ~m_open};
      4: return {24'h0, m_cm};
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pins(input string tag);
    compare({tag, " alt_sel_o"}, {24'h0, alt_sel}, {24'h0, m_fn});
    compare({tag, " pull_up_o"}, {24'h0, pull_up}, {24'h0, m_pu});
    compare({tag, " dig_en_o"},  {24'h0, dig_en},  {24'h0, m_de});
  endtask

  // monitor: pops an expected item for every returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected rd_valid_o, got %h expected none", rd_data);
      end else begin
        compare(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 reset rd_valid_o", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pins("R1 R2 R3 reset");
    rd(0, "R1 fn reset");
    rd(1, "R2 pu reset");
    rd(2, "R3 de reset");
    rd(3, "R5 closed after reset");
    rd(4, "R8 commit reset");
    rd(7, "R10 unmapped 7");
    // gate closed: protected bits hold, free bits follow
    wr(0, 32'h0000_0000);
    rd(0, "R6 fn locked write zero");
    wr(0, 32'h0000_00F0);
    rd(0, "R9 fn free bits while closed");
    pins("R6 R9 pins");
    wr(4, 32'h0000_000F);
    rd(4, "R8 commit write while closed");
    // open the gate, mask still clear
    wr(3, KEY);
    rd(3, "R5 open after key");
    wr(1, 32'h0000_0000);
    rd(1, "R7 pu open but uncommitted");
    wr(4, 32'h0000_00F5);
    rd(4, "R8 commit write while open");
    wr(0, 32'h0000_0000);
    rd(0, "R4 fn committed clear");
    pins("R4 pins after clear");
    wr(2, 32'h0000_00A0);
    rd(2, "R7 R9 de mixed");
    // non-key value closes the gate
    wr(3, KEY + 32'd1);
    rd(3, "R5 closed after other value");
    wr(0, 32'h0000_00FF);
    rd(0, "R6 fn after relock");
    wr(4, 32'h0000_0000);
    rd(4, "R8 commit held while closed");
    wr(3, KEY);
    wr(0, 32'h0000_0005);
    rd(0, "R7 fn committed set");
    pins("R4 R7 pins final");
    rd(5, "R10 unmapped 5");
    rd(15, "R10 unmapped 15");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10: pending reads got %0d expected 0", exp_q.size());
    end
    report();
  end
endmodule